// File: doc/BRIEF.md
# Event Channel Group Controller

This block keeps the enable state of a bank of event-routing channels. Every channel can be switched on or off by itself, and the channels can also be collected into a fixed number of groups that are switched on or off together. Software reaches the block over a simple register bus with a write strobe, a read strobe and a word address. Channels are switched through a write-one-to-set alias and a write-one-to-clear alias, so no read-modify-write of the enable state is ever needed.

Each group owns two triggers: one that switches on every member channel and one that switches them off. A trigger fires when software writes to it. It also fires when the channel event it subscribes to pulses while that channel is enabled, so hardware events can switch groups without software help. The output is the current channel-enable vector, which the routing fabric outside this block uses to gate its channels.

Top module: `evg_ctrl`

## Requirements
- R1: After reset every channel is disabled, every group membership register reads 0 and every subscription register reads 0.
- R2: A read of address 0x100 returns the channel-enable vector, with bit n holding channel n and unused upper bits 0. The same vector drives `chan_en_o`.
- R3: A write to address 0x104 enables every channel whose data bit is 1. Zero bits leave their channels unchanged.
- R4: A write to address 0x108 disables every channel whose data bit is 1. Zero bits leave their channels unchanged, and writing all ones disables every channel.
- R5: Group g has a read/write membership register at 0x180 + 4*g with one bit per channel. Writing 0 empties the group.
- R6: The on-trigger of group g sits at 8*g and its off-trigger at 8*g + 4. A write with data bit 0 set fires the trigger. A write with bit 0 clear has no effect. Reads of trigger addresses return 0.
- R7: Each trigger has a subscription register 0x80 bytes above its own address. Bit 31 enables the subscription and bits 7:0 name the channel. The register reads back what was written, and writing 0 removes the subscription.
- R8: A one-cycle pulse on `evt_in[c]` fires every trigger whose subscription is enabled and names channel c, but only while channel c is enabled. A channel number at or above the channel count never fires.
- R9: Firing an on-trigger sets every channel in that group's membership. Firing an off-trigger clears every such channel. Within one cycle the alias write applies first, then all on-triggers, then all off-triggers, so an off-trigger wins over everything else and an on-trigger wins over a clear-alias write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as `bus_rd`, 0 when no read is made |
| evt_in | input | NUM_CH | Broadcast channel event pulses |
| chan_en_o | output | NUM_CH | Current channel-enable vector |

## Verification
The bench builds the block with 16 channels and six groups. The narrower bank makes the unused upper bits of the status word visible, so the all-ones clear write and the read-back zeros above bit 15 can be checked. A subscription is driven against a channel that is disabled and then enabled, which shows the gating. Event pulses are driven in the same cycle as alias writes so that the set, on-trigger and off-trigger ordering can be seen at the ports.

// File: rtl/evg_pkg.sv
package evg_pkg;

  // Register word offsets (bytes); trigger/subscription spacing is behavioural.
  localparam int ADR_TASK_BASE = 'h000;
  localparam int ADR_SUB_OFS   = 'h080;
  localparam int ADR_STATUS    = 'h100;
  localparam int ADR_SET       = 'h104;
  localparam int ADR_CLR       = 'h108;
  localparam int ADR_GRP_BASE  = 'h180;
  localparam int WORD_W        = 32;

  typedef struct packed {
    logic       en;
    logic [7:0] ch;
  } sub_cfg_t;

  // Address of trigger t (t = 2*group + is_off).
  function automatic int task_addr(input int t);
    return ADR_TASK_BASE + 4 * t;
  endfunction

  function automatic int sub_addr(input int t);
    return task_addr(t) + ADR_SUB_OFS;
  endfunction

  function automatic int grp_addr(input int g);
    return ADR_GRP_BASE + 4 * g;
  endfunction

  // Ordered update: alias set/clear, then group on, then group off.
  function automatic logic [WORD_W-1:0] next_enable(
    input logic [WORD_W-1:0] cur,
    input logic [WORD_W-1:0] set_m,
    input logic [WORD_W-1:0] clr_m,
    input logic [WORD_W-1:0] on_m,
    input logic [WORD_W-1:0] off_m);
    logic [WORD_W-1:0] v;
    v = (cur | set_m) & ~clr_m;
    v = v | on_m;
    v = v & ~off_m;
    return v;
  endfunction

  function automatic logic [WORD_W-1:0] sub_word(input sub_cfg_t c);
    return {c.en, 23'd0, c.ch};
  endfunction

endpackage

// File: rtl/evg_regdec.sv
module evg_regdec
  import evg_pkg::*;
#(
  parameter int NUM_GRP = 6,
  parameter int ADDR_W  = 12,
  localparam int NUM_TASK = 2 * NUM_GRP
) (
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] set_mask,
  output logic [WORD_W-1:0] clr_mask,
  output logic [NUM_TASK-1:0] task_wr,
  output logic [NUM_TASK-1:0] sub_wr,
  output logic [NUM_GRP-1:0]  grp_wr
);

  logic set_hit, clr_hit;
  logic [NUM_TASK-1:0] task_hit;

  assign set_hit  = wr && (addr == ADDR_W'(ADR_SET));
  assign clr_hit  = wr && (addr == ADDR_W'(ADR_CLR));
  assign set_mask = set_hit ? wdata : '0;
  assign clr_mask = clr_hit ? wdata : '0;

  for (genvar t = 0; t < NUM_TASK; t++) begin : g_task
    assign task_hit[t] = wr && (addr == ADDR_W'(task_addr(t)));
    assign task_wr[t]  = task_hit[t] && wdata[0];
    assign sub_wr[t]   = wr && (addr == ADDR_W'(sub_addr(t)));
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    assign grp_wr[g] = wr && (addr == ADDR_W'(grp_addr(g)));
  end

  always_comb begin
    AST_DEC_ONEHOT: assert ($onehot0({task_hit, sub_wr, grp_wr, set_hit, clr_hit})); // R6
  end

endmodule

// File: rtl/evg_sub_slot.sv
module evg_sub_slot
  import evg_pkg::*;
#(
  parameter int NUM_CH = 32,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  sub_cfg_t          wcfg,
  input  logic [NUM_CH-1:0] evt_in,
  input  logic [NUM_CH-1:0] chan_en,
  output sub_cfg_t          cfg_q,
  output logic              fire
);

  logic            in_range;
  logic [CH_W-1:0] idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else if (wr) cfg_q <= wcfg;
  end

  assign in_range = (32'(cfg_q.ch) < NUM_CH);
  assign idx      = cfg_q.ch[CH_W-1:0];
  assign fire     = cfg_q.en && in_range && evt_in[idx] && chan_en[idx];

  AST_SUB_REMOVED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wcfg == '0) |=> !fire); // R7

  AST_SUB_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (cfg_q == $past(wcfg))); // R7

endmodule

// File: rtl/evg_chan_state.sv
module evg_chan_state
  import evg_pkg::*;
#(
  parameter int NUM_CH  = 32,
  parameter int NUM_GRP = 6
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_CH-1:0]               set_mask,
  input  logic [NUM_CH-1:0]               clr_mask,
  input  logic [NUM_GRP-1:0]              on_fire,
  input  logic [NUM_GRP-1:0]              off_fire,
  input  logic [NUM_GRP-1:0][NUM_CH-1:0]  grp_mask,
  output logic [NUM_CH-1:0]               chan_q
);

  logic [NUM_CH-1:0] on_or, off_or;
  logic [WORD_W-1:0] nxt_w;

  always_comb begin
    on_or  = '0;
    off_or = '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      if (on_fire[g])  on_or  = on_or  | grp_mask[g];
      if (off_fire[g]) off_or = off_or | grp_mask[g];
    end
  end

  assign nxt_w = next_enable(WORD_W'(chan_q), WORD_W'(set_mask), WORD_W'(clr_mask),
                             WORD_W'(on_or), WORD_W'(off_or));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chan_q <= '0;
    else        chan_q <= nxt_w[NUM_CH-1:0];
  end

  AST_SET_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
    ((|set_mask) && !(|off_or)) |=> ((chan_q & $past(set_mask)) == $past(set_mask))); // R3

  AST_CLR_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
    ((|clr_mask) && !(|on_or)) |=> ((chan_q & $past(clr_mask)) == '0)); // R4

  AST_OFF_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|off_or) |=> ((chan_q & $past(off_or)) == '0)); // R9

  AST_ON_OVER_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    ((|on_or) && !(|off_or)) |=> ((chan_q & $past(on_or)) == $past(on_or))); // R9

  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(|{set_mask, clr_mask, on_fire, off_fire}) |=> $stable(chan_q)); // R9

endmodule

// File: rtl/evg_ctrl.sv
module evg_ctrl
  import evg_pkg::*;
#(
  parameter int NUM_CH  = 32,
  parameter int NUM_GRP = 6,
  parameter int ADDR_W  = 12,
  localparam int NUM_TASK = 2 * NUM_GRP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NUM_CH-1:0] evt_in,
  output logic [NUM_CH-1:0] chan_en_o
);

  logic [WORD_W-1:0]   set_w, clr_w;
  logic [NUM_TASK-1:0] task_wr, sub_wr, sub_fire, task_fire;
  logic [NUM_GRP-1:0]  grp_wr, on_fire, off_fire;
  logic [NUM_GRP-1:0][NUM_CH-1:0] grp_q;
  sub_cfg_t            sub_q [NUM_TASK];
  sub_cfg_t            wcfg;
  logic [NUM_CH-1:0]   chan_q;
  logic [WORD_W-1:0]   rd_mux;

  evg_regdec #(.NUM_GRP(NUM_GRP), .ADDR_W(ADDR_W)) u_dec (
    .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .set_mask(set_w), .clr_mask(clr_w),
    .task_wr(task_wr), .sub_wr(sub_wr), .grp_wr(grp_wr)
  );

  assign wcfg = '{en: bus_wdata[31], ch: bus_wdata[7:0]};

  for (genvar t = 0; t < NUM_TASK; t++) begin : g_sub
    evg_sub_slot #(.NUM_CH(NUM_CH)) u_sub (
      .clk(clk), .rst_n(rst_n), .wr(sub_wr[t]), .wcfg(wcfg),
      .evt_in(evt_in), .chan_en(chan_q),
      .cfg_q(sub_q[t]), .fire(sub_fire[t])
    );
  end

  assign task_fire = task_wr | sub_fire;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    assign on_fire[g]  = task_fire[2*g];
    assign off_fire[g] = task_fire[2*g+1];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         grp_q[g] <= '0;
      else if (grp_wr[g]) grp_q[g] <= bus_wdata[NUM_CH-1:0];
    end

    AST_GRP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      grp_wr[g] |=> (grp_q[g] == $past(bus_wdata[NUM_CH-1:0]))); // R5
  end

  evg_chan_state #(.NUM_CH(NUM_CH), .NUM_GRP(NUM_GRP)) u_state (
    .clk(clk), .rst_n(rst_n),
    .set_mask(set_w[NUM_CH-1:0]), .clr_mask(clr_w[NUM_CH-1:0]),
    .on_fire(on_fire), .off_fire(off_fire), .grp_mask(grp_q),
    .chan_q(chan_q)
  );

  always_comb begin
    rd_mux = '0;
    if (bus_addr == ADDR_W'(ADR_STATUS)) rd_mux = WORD_W'(chan_q);
    for (int g = 0; g < NUM_GRP; g++)
      if (bus_addr == ADDR_W'(grp_addr(g))) rd_mux = WORD_W'(grp_q[g]);
    for (int t = 0; t < NUM_TASK; t++)
      if (bus_addr == ADDR_W'(sub_addr(t))) rd_mux = sub_word(sub_q[t]);
  end

  assign bus_rdata = bus_rd ? rd_mux : '0;
  assign chan_en_o = chan_q;

  AST_TASK_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr < ADDR_W'(task_addr(NUM_TASK))) |-> (bus_rdata == '0)); // R6

  AST_STATUS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_W'(ADR_STATUS)) |-> (bus_rdata == WORD_W'(chan_en_o))); // R2

endmodule

// File: tb/tb_evg_ctrl.sv
module tb_evg_ctrl;

  localparam int NCH = 16;
  localparam int NG  = 6;
  localparam int AW  = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NCH-1:0] evt_in = '0;
  logic [NCH-1:0] chan_en_o;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  always #2 clk = ~clk;  // 250 MHz

  evg_ctrl #(.NUM_CH(NCH), .NUM_GRP(NG), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_in(evt_in), .chan_en_o(chan_en_o)
  );

  // Monitor: compares each read against the next scoreboard item.
  always @(negedge clk) begin
    if (bus_rd) begin
      item_t it;
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL scoreboard empty: actual %h expected none", bus_rdata);
      end else begin
        it = sb.pop_front();
        if (bus_rdata !== it.exp) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", it.tag, bus_rdata, it.exp);
        end
      end
    end
  end

  task automatic cyc(input logic wr, input logic [AW-1:0] a,
                     input logic [31:0] d, input logic [NCH-1:0] ev);
    @(posedge clk); #1;
    bus_wr = wr; bus_rd = 1'b0; bus_addr = a; bus_wdata = d; evt_in = ev;
    @(posedge clk); #1;
    bus_wr = 1'b0; evt_in = '0;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    cyc(1'b1, a, d, '0);
  endtask

  task automatic pulse(input logic [NCH-1:0] ev);
    cyc(1'b0, '0, '0, ev);
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
    item_t it;
    it.exp = exp; it.tag = tag;
    sb.push_back(it);
    @(posedge clk); #1;
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic chk_out(input logic [NCH-1:0] exp, input string tag);
    checks++;
    if (chan_en_o !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, chan_en_o, exp);
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    chk_out('0, "R1 reset outputs");
    rd(12'h100, 32'h0, "R1 status after reset");
    rd(12'h180, 32'h0, "R1 group0 after reset");
    rd(12'h094, 32'h0, "R1 subscription after reset");

    // R3 / R2 set alias
    wr(12'h104, 32'h0000_00F0);
    rd(12'h100, 32'h0000_00F0, "R3 R2 set alias");
    // R4 clear alias
    wr(12'h108, 32'h0000_0030);
    rd(12'h100, 32'h0000_00C0, "R4 clear alias");

    // R5 membership
    wr(12'h180, 32'h0000_000F);
    wr(12'h184, 32'h0000_00C0);
    rd(12'h180, 32'h0000_000F, "R5 group0 readback");
    rd(12'h184, 32'h0000_00C0, "R5 group1 readback");

    // R6 triggers
    wr(12'h000, 32'h1);
    rd(12'h100, 32'h0000_00CF, "R6 group0 on-trigger");
    wr(12'h00C, 32'h2);
    rd(12'h100, 32'h0000_00CF, "R6 write without bit0 ignored");
    wr(12'h00C, 32'h1);
    rd(12'h100, 32'h0000_000F, "R6 group1 off-trigger");
    rd(12'h000, 32'h0, "R6 trigger address reads zero");

    // R7 / R8 subscription
    wr(12'h088, 32'h8000_0002);
    rd(12'h088, 32'h8000_0002, "R7 subscription readback");
    pulse(16'h0004);
    rd(12'h100, 32'h0000_00CF, "R8 event fires group1 on-trigger");

    wr(12'h084, 32'h8000_0006);
    wr(12'h108, 32'h0000_0040);
    pulse(16'h0040);
    rd(12'h100, 32'h0000_008F, "R8 disabled channel does not fire");
    wr(12'h104, 32'h0000_0040);
    pulse(16'h0040);
    rd(12'h100, 32'h0000_00C0, "R8 enabled channel fires group0 off");

    wr(12'h080, 32'h0000_0007);
    pulse(16'h0080);
    rd(12'h100, 32'h0000_00C0, "R8 subscription without enable bit");
    wr(12'h080, 32'h8000_0007);
    pulse(16'h0080);
    rd(12'h100, 32'h0000_00CF, "R8 subscribed group0 on");
    wr(12'h080, 32'h0);
    rd(12'h080, 32'h0, "R7 subscription removed readback");
    wr(12'h108, 32'h0000_000F);
    pulse(16'h0080);
    rd(12'h100, 32'h0000_00C0, "R7 removed subscription does not fire");

    // R9 ordering
    wr(12'h080, 32'h8000_0007);
    cyc(1'b1, 12'h104, 32'h0000_0100, 16'h00C0);
    rd(12'h100, 32'h0000_01C0, "R9 off-trigger wins over on-trigger");
    cyc(1'b1, 12'h108, 32'h0000_0001, 16'h0080);
    rd(12'h100, 32'h0000_01CF, "R9 on-trigger wins over clear alias");
    chk_out(16'h01CF, "R2 output matches status");

    // R4 all ones clear, R5 empty group
    wr(12'h108, 32'hFFFF_FFFF);
    rd(12'h100, 32'h0, "R4 clear all");
    wr(12'h180, 32'h0);
    rd(12'h180, 32'h0, "R5 group emptied");
    wr(12'h000, 32'h1);
    rd(12'h100, 32'h0, "R5 empty group on-trigger has no effect");

    repeat (2) @(posedge clk);
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL scoreboard leftover: actual %0d expected 0", sb.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule